// File: doc/BRIEF.md
# Synchronous Exception Priority Selector

This block sits beside the execute/writeback stage of an in-order core. For each instruction presented with a valid strobe, it collects the exception conditions already flagged for it. These are fetch-side faults, decode results (illegal encoding, environment call, breakpoint) and the attributes of its data access. From these it works out the access-side faults itself. It then picks the single most urgent one and reports it as a trap request carrying a machine cause word. The cause word has the interrupt bit cleared. Exceptions have no enable or mask.

The access-side rules decide how a badly aligned data address is reported. For an atomic access (load-reserved, store-conditional or AMO), a bad alignment is reported as a misaligned-address exception, but only when no access fault applies to that access. For a plain load or store, a bad alignment never raises a misaligned-address code. It becomes an access fault when it targets an I/O region, and it causes no trap anywhere else. A flush in the same cycle as the valid strobe discards the instruction, including any fetch faults attached to it.

The control is a two-state machine. ST_IDLE presents no trap. ST_TRAP presents the registered cause together with trap_valid_o. The machine goes from ST_IDLE or ST_TRAP to ST_TRAP when a valid, unflushed instruction has at least one condition. On any other cycle it goes to ST_IDLE, so the trap request is a one-cycle pulse per instruction.

Top module: `exc_sel_unit`

## Requirements
- R1: While rst_n is low and after its release, trap_valid_o is 0 and cause_o is 0 until a faulting instruction is accepted.
- R2: A valid, unflushed instruction with at least one condition produces trap_valid_o = 1 on the clock edge that accepts it. The pulse lasts one cycle unless the next instruction also traps.
- R3: flush_i high in the same cycle as valid_i suppresses the trap completely, including instruction access and instruction bus faults.
- R4: With valid_i low, no input produces a trap.
- R5: When several conditions apply, the reported code follows the order, from highest to lowest: 1 (instruction access fault), 24 (instruction bus fault), 2 (illegal), 11 (environment call), 3 (breakpoint), 7 (store/AMO access fault), 5 (load access fault), 6 (store/AMO misaligned), 4 (load misaligned).
- R6: cause_o has bit 31 at 0 and holds the code zero-extended in its low bits. When trap_valid_o is 0, cause_o is 0.
- R7: mem_op_i is encoded as 0 none, 1 load, 2 store, 3 load-reserved, 4 store-conditional, 5 AMO; 6 and 7 behave as none. A load (1 or 3) raises code 5 in three cases: it is misaligned to an I/O region, it is a modified access to an I/O region, or it is a load-reserved with atomic_ok_i low.
- R8: A store, store-conditional or AMO (2, 4, 5) raises code 7 in three cases: it is misaligned to an I/O region, it is a modified access to an I/O region, or it is a store-conditional/AMO with atomic_ok_i low.
- R9: Code 4 is raised only for load-reserved, and code 6 only for store-conditional or AMO. In both cases misaligned_i must be high and no access fault may apply to the access.
- R10: A misaligned plain load or store outside an I/O region raises no trap. With mem_op_i none, the misaligned, I/O, modified and atomic qualifiers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| flush_i | input | 1 | The presented instruction is discarded |
| fetch_acc_flt_i | input | 1 | Fetch was from a non-executable (I/O) region |
| fetch_bus_flt_i | input | 1 | Fetch returned a bus error |
| illegal_i | input | 1 | Illegal encoding |
| ecall_i | input | 1 | Environment call |
| ebreak_i | input | 1 | Environment break |
| mem_op_i | input | 3 | Data access kind (see R7) |
| misaligned_i | input | 1 | Data address not naturally aligned |
| io_region_i | input | 1 | Data address lies in an I/O region |
| modified_i | input | 1 | Access is modified (e.g. split) |
| atomic_ok_i | input | 1 | Region supports atomic operations |
| trap_valid_o | output | 1 | One-cycle trap request |
| cause_o | output | 32 | Cause word for the trap |

## Verification
The checker verifies on every cycle the cycle-level rules: flushed or absent instructions never trap, the cause word has its interrupt bit clear and is zero when no trap is shown, an instruction access fault always wins, and plain loads and stores never yield a misaligned code. The full priority order and the access-fault and misalignment classification depend on each combination of the qualifiers. Only the bench shows these, by sweeping every combination of flags, access kind and region attributes under all valid/flush settings and comparing against a model computed from the requirements.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

    localparam int XLEN    = 32;
    localparam int CODE_W  = 5;
    localparam int NUM_SRC = 9;

    // data access kinds
    localparam logic [2:0] MOP_NONE  = 3'd0;
    localparam logic [2:0] MOP_LOAD  = 3'd1;
    localparam logic [2:0] MOP_STORE = 3'd2;
    localparam logic [2:0] MOP_LR    = 3'd3;
    localparam logic [2:0] MOP_SC    = 3'd4;
    localparam logic [2:0] MOP_AMO   = 3'd5;

    // cause codes
    localparam logic [CODE_W-1:0] C_INSTR_ACC = 5'd1;
    localparam logic [CODE_W-1:0] C_ILLEGAL   = 5'd2;
    localparam logic [CODE_W-1:0] C_BREAK     = 5'd3;
    localparam logic [CODE_W-1:0] C_LD_MIS    = 5'd4;
    localparam logic [CODE_W-1:0] C_LD_ACC    = 5'd5;
    localparam logic [CODE_W-1:0] C_ST_MIS    = 5'd6;
    localparam logic [CODE_W-1:0] C_ST_ACC    = 5'd7;
    localparam logic [CODE_W-1:0] C_ECALL     = 5'd11;
    localparam logic [CODE_W-1:0] C_BUS_FLT   = 5'd24;

    // request slots, index 0 is most urgent
    localparam logic [CODE_W-1:0] PRIO_CODE [NUM_SRC] = '{
        C_INSTR_ACC, C_BUS_FLT, C_ILLEGAL, C_ECALL, C_BREAK,
        C_ST_ACC, C_LD_ACC, C_ST_MIS, C_LD_MIS
    };

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } state_e;

endpackage

// File: rtl/mem_fault_classify.sv
module mem_fault_classify
    import exc_sel_pkg::*;
(
    input  logic [2:0] mem_op,
    input  logic       misaligned,
    input  logic       io_region,
    input  logic       modified,
    input  logic       atomic_ok,
    output logic       ld_acc,
    output logic       st_acc,
    output logic       ld_mis,
    output logic       st_mis
);

    logic is_ld, is_st, is_lr, is_scamo, io_bad;

    always_comb begin
        is_lr    = (mem_op == MOP_LR);
        is_scamo = (mem_op == MOP_SC) || (mem_op == MOP_AMO);
        is_ld    = (mem_op == MOP_LOAD) || is_lr;
        is_st    = (mem_op == MOP_STORE) || is_scamo;
        io_bad   = io_region && (misaligned || modified);

        ld_acc = is_ld && (io_bad || (is_lr && !atomic_ok));
        st_acc = is_st && (io_bad || (is_scamo && !atomic_ok));
        ld_mis = is_lr && misaligned && !ld_acc;
        st_mis = is_scamo && misaligned && !st_acc;
    end

endmodule

// File: rtl/excp_prio_pick.sv
module excp_prio_pick
    import exc_sel_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]      req,
    output logic              hit,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        hit  = |req;
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                code = PRIO_CODE[i];
            end
        end
    end

endmodule

// File: rtl/exc_sel_unit.sv
module exc_sel_unit
    import exc_sel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic            flush_i,
    input  logic            fetch_acc_flt_i,
    input  logic            fetch_bus_flt_i,
    input  logic            illegal_i,
    input  logic            ecall_i,
    input  logic            ebreak_i,
    input  logic [2:0]      mem_op_i,
    input  logic            misaligned_i,
    input  logic            io_region_i,
    input  logic            modified_i,
    input  logic            atomic_ok_i,
    output logic            trap_valid_o,
    output logic [XLEN-1:0] cause_o
);

    logic ld_acc, st_acc, ld_mis, st_mis;
    logic [NUM_SRC-1:0] req;
    logic               any_req;
    logic [CODE_W-1:0]  win_code;
    logic               take;
    state_e             state_q, state_d;
    logic [XLEN-1:0]    cause_q;

    mem_fault_classify i_cls (
        .mem_op     (mem_op_i),
        .misaligned (misaligned_i),
        .io_region  (io_region_i),
        .modified   (modified_i),
        .atomic_ok  (atomic_ok_i),
        .ld_acc     (ld_acc),
        .st_acc     (st_acc),
        .ld_mis     (ld_mis),
        .st_mis     (st_mis)
    );

    assign req = {ld_mis, st_mis, ld_acc, st_acc, ebreak_i, ecall_i,
                  illegal_i, fetch_bus_flt_i, fetch_acc_flt_i};

    excp_prio_pick #(.N(NUM_SRC)) i_pick (
        .req  (req),
        .hit  (any_req),
        .code (win_code)
    );

    assign take = valid_i && !flush_i && any_req;

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = take ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_d = take ? ST_TRAP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (take) begin
            cause_q <= {{(XLEN-CODE_W){1'b0}}, win_code};
        end else begin
            cause_q <= '0;
        end
    end

    assign trap_valid_o = (state_q == ST_TRAP);
    assign cause_o      = cause_q;

endmodule

// File: rtl/exc_sel_checker.sv
module exc_sel_checker
    import exc_sel_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            valid_i,
    input logic            flush_i,
    input logic            fetch_acc_flt_i,
    input logic [2:0]      mem_op_i,
    input logic            trap_valid_o,
    input logic [XLEN-1:0] cause_o
);

    AST_FLUSH_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && flush_i) |=> !trap_valid_o); // R3

    AST_NO_VALID_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !trap_valid_o); // R4

    AST_CAUSE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> (cause_o[XLEN-1:CODE_W] == '0)); // R6

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_o |-> (cause_o == '0)); // R6

    AST_FETCH_ACC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !flush_i && fetch_acc_flt_i)
            |=> (trap_valid_o && cause_o == XLEN'(1))); // R5

    AST_PLAIN_NO_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (mem_op_i == MOP_LOAD || mem_op_i == MOP_STORE))
            |=> !(cause_o == XLEN'(4) || cause_o == XLEN'(6))); // R9

endmodule

bind exc_sel_unit exc_sel_checker i_exc_sel_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .valid_i         (valid_i),
    .flush_i         (flush_i),
    .fetch_acc_flt_i (fetch_acc_flt_i),
    .mem_op_i        (mem_op_i),
    .trap_valid_o    (trap_valid_o),
    .cause_o         (cause_o)
);

// File: tb/test_exc_sel_unit.sv
module test_exc_sel_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0, flush_i = 1'b0;
    logic        fetch_acc_flt_i = 1'b0, fetch_bus_flt_i = 1'b0;
    logic        illegal_i = 1'b0, ecall_i = 1'b0, ebreak_i = 1'b0;
    logic [2:0]  mem_op_i = 3'd0;
    logic        misaligned_i = 1'b0, io_region_i = 1'b0;
    logic        modified_i = 1'b0, atomic_ok_i = 1'b0;
    logic        trap_valid_o;
    logic [31:0] cause_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    exc_sel_unit i_exc_sel_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .flush_i(flush_i),
        .fetch_acc_flt_i(fetch_acc_flt_i), .fetch_bus_flt_i(fetch_bus_flt_i),
        .illegal_i(illegal_i), .ecall_i(ecall_i), .ebreak_i(ebreak_i),
        .mem_op_i(mem_op_i), .misaligned_i(misaligned_i),
        .io_region_i(io_region_i), .modified_i(modified_i),
        .atomic_ok_i(atomic_ok_i), .trap_valid_o(trap_valid_o),
        .cause_o(cause_o)
    );

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {valid,cause}=%h expected %h", req, act, exp);
        end
    endtask

    // model built from the requirements: returns 0 for no trap
    function automatic int model(input logic [11:0] c);
        logic fa, fb, il, ec, eb, mis, io, md, aok;
        logic [2:0] op;
        logic ld, st, lr, sa, lacc, sacc;
        fa = c[0]; fb = c[1]; il = c[2]; ec = c[3]; eb = c[4];
        op = c[7:5]; mis = c[8]; io = c[9]; md = c[10]; aok = c[11];
        lr = (op == 3);
        sa = (op == 4) || (op == 5);
        ld = (op == 1) || lr;
        st = (op == 2) || sa;
        lacc = ld && ((mis && io) || (md && io) || (lr && !aok));
        sacc = st && ((mis && io) || (md && io) || (sa && !aok));
        if (fa) return 1;
        if (fb) return 24;
        if (il) return 2;
        if (ec) return 11;
        if (eb) return 3;
        if (sacc) return 7;
        if (lacc) return 5;
        if (sa && mis) return 6;
        if (lr && mis) return 4;
        return 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", {trap_valid_o, cause_o}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {trap_valid_o, cause_o}, 33'd0);

        for (int vf = 0; vf < 4; vf++) begin
            for (int c = 0; c < 4096; c++) begin
                logic [11:0] cv;
                int exp_code;
                string tag;
                cv = 12'(c);
                valid_i = vf[0]; flush_i = vf[1];
                fetch_acc_flt_i = cv[0]; fetch_bus_flt_i = cv[1];
                illegal_i = cv[2]; ecall_i = cv[3]; ebreak_i = cv[4];
                mem_op_i = cv[7:5]; misaligned_i = cv[8]; io_region_i = cv[9];
                modified_i = cv[10]; atomic_ok_i = cv[11];
                exp_code = (vf == 1) ? model(cv) : 0;
                if (vf[0] == 1'b0)           tag = "R4";
                else if (vf[1])              tag = "R3";
                else if (exp_code == 0)      tag = "R10";
                else if (exp_code == 4 || exp_code == 6) tag = "R9";
                else if (exp_code == 5)      tag = "R7";
                else if (exp_code == 7)      tag = "R8";
                else                         tag = "R5";
                @(negedge clk);
                check(tag, {trap_valid_o, cause_o},
                      {(exp_code != 0), 32'(exp_code)});
                if (trap_valid_o) begin
                    check("R6", {1'b0, cause_o[31:5], 5'd0}, 33'd0);
                end
                // idle cycle: pulse must end (R2)
                valid_i = 1'b0; flush_i = 1'b0;
                @(negedge clk);
                check("R2", {trap_valid_o, cause_o}, 33'd0);
            end
        end

        // R2: back-to-back traps keep the request up with the new cause
        valid_i = 1'b1; flush_i = 1'b0;
        fetch_acc_flt_i = 1'b0; fetch_bus_flt_i = 1'b0; illegal_i = 1'b1;
        ecall_i = 1'b0; ebreak_i = 1'b0; mem_op_i = 3'd0;
        @(negedge clk);
        check("R2", {trap_valid_o, cause_o}, {1'b1, 32'd2});
        illegal_i = 1'b0; ebreak_i = 1'b1;
        @(negedge clk);
        check("R2", {trap_valid_o, cause_o}, {1'b1, 32'd3});
        valid_i = 1'b0; ebreak_i = 1'b0;
        @(negedge clk);
        check("R2", {trap_valid_o, cause_o}, 33'd0);

        finish_run();
    end

endmodule